// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

A 32-pin general-purpose I/O port controlled through a simple single-cycle register port. Software drives the pins through an output-data register and an output-enable register, and reads the synchronised pin levels back from a read-only input register. Each pin can also raise an interrupt. A pin-select register chooses which pins may take part. Two per-pin mode bits, level-select and polarity, pick rising edge, falling edge, high level or low level detection.

Detected events set bits in a sticky status register. Only a write to that register's clear alias removes them. The status is masked by a per-pin enable and reduced to one port interrupt line. Every writable register has three write addresses: a plain write that replaces the value, a set alias that ORs in the ones written, and a clear alias that removes the ones written. Software can therefore change single bits without a read-modify-write sequence.

The design has no state machine. Its sequential state is the register bank, the input synchroniser and the status register. Each is updated on every clock edge from the decoded access type (none, write, set, clear) and the detected pin events.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and `irq_out` is low.
- R2: A write to a register's base offset (address bits [3:0] = 0x0) replaces its value on the next edge. `pin_out` follows the output-data register and `pin_oe` follows the output-enable register.
- R3: A write to offset 0x4 sets the bits written as one, and a write to offset 0x8 clears the bits written as one. All other bits keep their value, and an idle bus changes no register.
- R4: Address bits [7:4] select the register: 0 output data, 1 input data, 2 output enable, 3 pin select, 4 interrupt enable, 5 level-select, 6 polarity, 7 status. A read at any low offset returns that register, and indices 8 to 15 read zero.
- R5: The input-data register shows `pin_in` two clock edges after the pin changes, and writes to it are ignored.
- R6: With level-select 0 and polarity 1, a rising pin sets its status bit once, three edges after the pin change.
- R7: With level-select 0 and polarity 0, a falling pin sets its status bit once, three edges after the pin change.
- R8: With level-select 1, the status bit is set on every cycle the pin sits at the active level (polarity 1 high, polarity 0 low). A clear while that level persists has no lasting effect.
- R9: A pin whose pin-select bit is 0 never sets its status bit.
- R10: Status bits are removed only by the clear alias (0x78). Writes to 0x70 and 0x74 leave the status unchanged.
- R11: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R12: `irq_out` is high exactly when some status bit is set together with its interrupt-enable bit, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address: index in [7:4], access type in [3:0] |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output-data register to the pads |
| pin_oe | output | 32 | Output-enable register to the pads |
| irq_out | output | 1 | Port interrupt |

## Verification
A register write becomes visible after the edge that samples it. The input-data register follows a pin after two edges. A status bit, and with it `irq_out`, follows a qualifying pin change after three edges. Reads are combinational in the same cycle. The bench drives inputs on falling edges and advances its reference model on rising edges, so the model applies exactly these latencies. On every falling edge it compares `pin_out`, `pin_oe` and `irq_out`, and it compares `bus_rdata` one nanosecond after the address is set. The same-cycle clear test places the clear write precisely on the third edge after the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLR   = 2'd3
    } acc_kind_e;

    localparam int REG_DOUT = 0;
    localparam int REG_DIN  = 1;
    localparam int REG_OE   = 2;
    localparam int REG_SEL  = 3;
    localparam int REG_EN   = 4;
    localparam int REG_LEV  = 5;
    localparam int REG_POL  = 6;
    localparam int REG_STAT = 7;
    localparam int NUM_REGS = 8;

    function automatic acc_kind_e decode_kind(input logic wr, input logic [3:0] lo);
        if (!wr)            return ACC_NONE;
        else if (lo == 4'h0) return ACC_WRITE;
        else if (lo == 4'h4) return ACC_SET;
        else if (lo == 4'h8) return ACC_CLR;
        else                return ACC_NONE;
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  acc_kind_e    kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (hit) begin
            unique case (kind)
                ACC_WRITE: q <= wdata;
                ACC_SET:   q <= q | wdata;
                ACC_CLR:   q <= q & ~wdata;
                default:   q <= q;
            endcase
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(q)); // R3

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] lev,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic hit_b;
        always_comb begin
            unique case ({lev[b], pol[b]})
                2'b00:   hit_b = prev[b] & ~cur[b];
                2'b01:   hit_b = cur[b] & ~prev[b];
                2'b10:   hit_b = ~cur[b];
                default: hit_b = cur[b];
            endcase
        end
        assign evt[b] = sel[b] & hit_b;
    end

endmodule

// File: rtl/gpio_stat.sv
module gpio_stat #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] sel,
    input  logic         clr_hit,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat_q
);

    logic [W-1:0] drop;

    assign drop = clr_hit ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~drop) | evt;
    end

    AST_CLEAR_ONLY_BY_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_q) & ~stat_q)) |-> $past(clr_hit)); // R10

    AST_SELECT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(sel)) == '0)); // R9

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt))); // R11

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              irq_out
);

    localparam int IDX_LSB = 4;
    localparam int IDX_W   = ADDR_W - IDX_LSB;

    logic [IDX_W-1:0] idx;
    acc_kind_e        kind;
    logic [PIN_W-1:0] bank [NUM_REGS];
    logic [PIN_W-1:0] sync_v, prev_v, evt_v, stat_v;

    assign idx  = bus_addr[ADDR_W-1:IDX_LSB];
    assign kind = decode_kind(bus_wr, bus_addr[3:0]);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == REG_DIN) begin : g_din
            assign bank[g] = sync_v;
        end else if (g == REG_STAT) begin : g_stat
            assign bank[g] = stat_v;
        end else begin : g_rw
            gpio_alias_reg #(.W(PIN_W)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .hit   ((kind != ACC_NONE) && (idx == IDX_W'(g))),
                .kind  (kind),
                .wdata (bus_wdata),
                .q     (bank[g])
            );
        end
    end

    gpio_sync #(.W(PIN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (sync_v),
        .prev_q (prev_v)
    );

    gpio_evt_detect #(.W(PIN_W)) u_evt (
        .cur  (sync_v),
        .prev (prev_v),
        .sel  (bank[REG_SEL]),
        .lev  (bank[REG_LEV]),
        .pol  (bank[REG_POL]),
        .evt  (evt_v)
    );

    gpio_stat #(.W(PIN_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_v),
        .sel      (bank[REG_SEL]),
        .clr_hit  ((kind == ACC_CLR) && (idx == IDX_W'(REG_STAT))),
        .clr_mask (bus_wdata),
        .stat_q   (stat_v)
    );

    always_comb begin
        if (idx < IDX_W'(NUM_REGS)) bus_rdata = bank[idx[2:0]];
        else                        bus_rdata = '0;
    end

    assign pin_out = bank[REG_DOUT];
    assign pin_oe  = bank[REG_OE];
    assign irq_out = |(stat_v & bank[REG_EN]);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|bank[REG_EN])); // R12

endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Behavioural reference: plain registers, a pin pipeline, per-bit rules
    logic [31:0] m_reg [8];
    logic [31:0] m_s1, m_s2, m_prev, m_stat;

    always @(posedge clk) begin
        logic [31:0] ev, wipe;
        int ridx;
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) m_reg[k] = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
        end else begin
            ev = '0;
            for (int i = 0; i < 32; i++) begin
                if (m_reg[3][i]) begin
                    if (m_reg[5][i])      ev[i] = (m_s2[i] == m_reg[6][i]);
                    else if (m_reg[6][i]) ev[i] = m_s2[i] && !m_prev[i];
                    else                  ev[i] = !m_s2[i] && m_prev[i];
                end
            end
            ridx = int'(bus_addr[7:4]);
            wipe = (bus_wr && ridx == 7 && bus_addr[3:0] == 4'h8) ? bus_wdata : '0;
            m_stat = (m_stat & ~wipe) | ev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (bus_wr && ridx < 7 && ridx != 1) begin
                case (bus_addr[3:0])
                    4'h0: m_reg[ridx] = bus_wdata;
                    4'h4: m_reg[ridx] = m_reg[ridx] | bus_wdata;
                    4'h8: m_reg[ridx] = m_reg[ridx] & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int r = int'(a[7:4]);
        if (r == 1) return m_s2;
        if (r == 7) return m_stat;
        if (r < 8)  return m_reg[r];
        return '0;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Every-clock comparison of the pin-side outputs (R2, R12)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", "pin_out", pin_out, m_reg[0]);
            check("R2", "pin_oe", pin_oe, m_reg[2]);
            check("R12", "irq_out", {31'd0, irq_out}, {31'd0, |(m_stat & m_reg[4])});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, "bus_rdata", bus_rdata, model_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "irq_out", {31'd0, irq_out}, 32'd0);
        check("R1", "pin_oe", pin_oe, 32'd0);
        for (int r = 0; r < 8; r++) rd(8'(r << 4), "R1");

        // R2, R3: plain write, set and clear aliases
        wr(8'h00, 32'hA5A5_0000); rd(8'h00, "R2");
        wr(8'h04, 32'h0F00_00F0); rd(8'h00, "R3");
        wr(8'h08, 32'h0500_0000); rd(8'h00, "R3");
        wr(8'h20, 32'h0000_FFFF); wr(8'h24, 32'h0001_0000); wr(8'h28, 32'h0000_0003);
        wr(8'h2C, 32'hFFFF_FFFF); // undefined offset: no change (R3)
        rd(8'h20, "R3");
        // R4: aliases read the same register, unmapped indices read zero
        rd(8'h24, "R4"); rd(8'h08, "R4"); rd(8'h90, "R4"); rd(8'hF0, "R4");

        // R5: input data follows pins after two edges, writes ignored
        @(negedge clk); pin_in = 32'h1234_5678;
        @(negedge clk); bus_addr = 8'h10; #1; check("R5", "din early", bus_rdata, model_read(8'h10));
        @(negedge clk); #1; check("R5", "din", bus_rdata, 32'h1234_5678);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); rd(8'h10, "R5");

        // Interrupt setup: pin0 rising, pin1 falling, pin2 low level, pin3 high level,
        // pin31 rising but not selected
        @(negedge clk); pin_in = 32'h0000_0002;
        idle(3);
        wr(8'h50, 32'h0000_000C);
        wr(8'h60, 32'h8000_0009);
        wr(8'h30, 32'h7FFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        idle(2);
        wr(8'h78, 32'hFFFF_FFFF);
        rd(8'h70, "R8"); // pin2 low level re-sets at once

        // R6: rising edge on pin0, status due three edges later
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_addr = 8'h70; #1; check("R6", "before third edge", bus_rdata & 32'h1, 32'h0);
        @(negedge clk); #1; check("R6", "status bit0", bus_rdata & 32'h1, 32'h1);
        wr(8'h78, 32'h1); rd(8'h70, "R6");
        idle(3); rd(8'h70, "R6"); // set only once per edge

        // R7: falling edge on pin1
        @(negedge clk); pin_in[1] = 1'b0;
        idle(3); rd(8'h70, "R7");
        wr(8'h78, 32'h2); idle(3); rd(8'h70, "R7");

        // R8: high level on pin3 persists through a clear
        @(negedge clk); pin_in[3] = 1'b1;
        idle(4); rd(8'h70, "R8");
        wr(8'h78, 32'h8); rd(8'h70, "R8");
        @(negedge clk); pin_in[3] = 1'b0;
        idle(3); wr(8'h78, 32'h8); rd(8'h70, "R8");

        // R9: unselected pin31 rises, no status
        @(negedge clk); pin_in[31] = 1'b1;
        idle(4); bus_addr = 8'h70; #1;
        check("R9", "status bit31", bus_rdata & 32'h8000_0000, 32'h0);

        // R10: base and set writes cannot touch status
        @(negedge clk); pin_in[0] = 1'b0; pin_in[1] = 1'b1;
        idle(4);
        wr(8'h70, 32'h0); rd(8'h70, "R10");
        wr(8'h74, 32'hFFFF_FFFF); rd(8'h70, "R10");
        wr(8'h78, 32'h0000_FFFB); rd(8'h70, "R10");

        // R11: falling pin1 event and clear of bit1 on the same edge
        @(negedge clk); pin_in[1] = 1'b0;
        @(negedge clk);
        @(negedge clk); bus_addr = 8'h78; bus_wr = 1'b1; bus_wdata = 32'h2;
        @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h70; #1;
        check("R11", "status bit1", bus_rdata & 32'h2, 32'h2);
        rd(8'h70, "R11");

        // R12: disabling enables drops irq while status stays
        wr(8'h48, 32'hFFFF_FFFF); rd(8'h70, "R12");
        check("R12", "irq masked", {31'd0, irq_out}, 32'd0);
        wr(8'h44, 32'h0000_0002);
        check("R12", "irq unmasked", {31'd0, irq_out}, 32'd1);
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule